// File: doc/BRIEF.md
# Standby One-Shot Conversion Trigger

This block sequences the conversion-and-compare cycles of a sensor that can run either continuously or in standby. In continuous mode a periodic scheduler raises a tick, and each tick that arrives while the converter is free starts one conversion. In standby the ticks are ignored. Software can request a single cycle by writing to a trigger address. After that conversion finishes, the block returns to standby and stays there.

The trigger address holds no data. Any value written to it starts the cycle, nothing written is kept, and reading it always returns zero. A configuration address holds only the standby control bit. The converter datapath, the limit comparison and the serial bus decoding sit outside this block. The block sees simple register-bus strobes and the converter's completion strobe.

Top module: `oneshot_seq`

## Requirements
- R1: After reset the block is in continuous mode, `busy`, `done`, `conv_start` and `rdata` are all 0.
- R2: In continuous mode with no conversion running, a `sched_tick` makes `conv_start` high in the next cycle, and `busy` rises in that same cycle.
- R3: `busy` stays high from the start pulse until the cycle after `conv_done`. `done` becomes 1 in that same cycle and clears when the next conversion starts. A `conv_done` while not busy has no effect.
- R4: Writing 1 to bit 6 of the configuration address (0x03) puts the block in standby within two cycles. In standby, `sched_tick` starts nothing.
- R5: In standby, a write to the trigger address (0x0F) starts exactly one conversion. When it completes, the block returns to standby and starts no further conversion.
- R6: The value written to the trigger address is ignored: 0x00, 0xFF and other values all trigger the cycle, and none of them is stored.
- R7: A read returns data one cycle after `rd_en`. The trigger address reads as 0x00. The configuration address reads as the standby bit in bit 6 with all other bits 0. Only bit 6 of a configuration write is stored.
- R8: A trigger write while a conversion is running is ignored and does not extend or restart it.
- R9: A trigger write in continuous mode is ignored. The scheduler alone decides when conversions start.
- R10: Writing 0 to the standby bit returns the block to continuous mode within two cycles, after which ticks start conversions again.
- R11: `conv_start` is high for exactly one cycle per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| sched_tick | input | 1 | Periodic conversion request from the scheduler |
| conv_done | input | 1 | Converter completion strobe |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Last started conversion has completed |

## Verification
Every result in this block comes one register stage after the stimulus that caused it. `conv_start`, `busy`, `done` and `rdata` change on the edge that samples a tick, a trigger write, a completion strobe or a read. The bench therefore drives each stimulus for one cycle and checks the outputs just after the next rising edge. The standby bit takes one edge to be stored and a second edge to move the state machine. So the vector table adds an idle row between a configuration write and the first stimulus that depends on the new mode, and the mode is checked only after that row.

// File: rtl/oneshot_seq.sv
module oneshot_seq #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 8'h0F,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h03,
  parameter int STBY_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sched_tick,
  input  logic              conv_done,
  output logic              conv_start,
  output logic              busy,
  output logic              done
);

  typedef enum logic [1:0] {S_CONT = 2'd0, S_STBY = 2'd1, S_CONV = 2'd2} state_t;

  state_t state;
  logic   stby_q;
  logic   trig_wr, cfg_wr, go;

  assign trig_wr = wr_en && (addr == TRIG_ADDR);
  assign cfg_wr  = wr_en && (addr == CFG_ADDR);
  assign go      = (state == S_STBY && stby_q && trig_wr) ||
                   (state == S_CONT && !stby_q && sched_tick);
  assign busy    = (state == S_CONV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_CONT;
      stby_q     <= 1'b0;
      conv_start <= 1'b0;
      done       <= 1'b0;
      rdata      <= '0;
    end else begin
      conv_start <= go;
      if (cfg_wr) stby_q <= wdata[STBY_BIT];
      if (go) done <= 1'b0;
      else if (busy && conv_done) done <= 1'b1;
      rdata <= '0;
      if (rd_en && addr == CFG_ADDR) rdata[STBY_BIT] <= stby_q;
      unique case (state)
        S_CONT: if (stby_q) state <= S_STBY;
                else if (go) state <= S_CONV;
        S_STBY: if (!stby_q) state <= S_CONT;
                else if (go) state <= S_CONV;
        S_CONV: if (conv_done) state <= stby_q ? S_STBY : S_CONT;
        default: state <= S_CONT;
      endcase
    end
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> busy); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && conv_done |=> !busy && done); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R11
  AST_START_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy && $past(state != S_CONV)); // R8
  AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == TRIG_ADDR |=> rdata == '0); // R7
  AST_STBY_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_STBY && !trig_wr |=> !conv_start); // R5
  AST_CONT_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CONT && !sched_tick |=> !conv_start); // R9

endmodule

// File: tb/oneshot_seq_tb.sv
module oneshot_seq_tb;
  localparam int HALF = 4;
  localparam int NV   = 24;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0, sched_tick = 0, conv_done = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic       conv_start, busy, done;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #HALF clk = ~clk;

  oneshot_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sched_tick(sched_tick), .conv_done(conv_done),
    .conv_start(conv_start), .busy(busy), .done(done)
  );

  // {wr, rd, addr, wdata, tick, cdone, exp_start, exp_busy, exp_done, exp_rdata, req}
  localparam logic [34:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,8'h00,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b0,8'h00, 4'd2},  // R2
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,8'h00, 4'd11}, // R11
    {1'b0,1'b0,8'h00,8'h00,1'b1,1'b0, 1'b0,1'b1,1'b0,8'h00, 4'd3},  // R3
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b1, 1'b0,1'b0,1'b1,8'h00, 4'd3},  // R3
    {1'b1,1'b0,8'h0F,8'hA5,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd9},  // R9
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b1, 1'b0,1'b0,1'b1,8'h00, 4'd3},  // R3 stray done
    {1'b1,1'b0,8'h03,8'h40,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd4},  // R4
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd4},  // R4
    {1'b0,1'b0,8'h00,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd4},  // R4
    {1'b0,1'b1,8'h03,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h40, 4'd7},  // R7
    {1'b0,1'b1,8'h0F,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd7},  // R7
    {1'b1,1'b0,8'h0F,8'h00,1'b0,1'b0, 1'b1,1'b1,1'b0,8'h00, 4'd6},  // R6
    {1'b1,1'b0,8'h0F,8'hFF,1'b0,1'b0, 1'b0,1'b1,1'b0,8'h00, 4'd8},  // R8
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b1, 1'b0,1'b0,1'b1,8'h00, 4'd5},  // R5
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd5},  // R5
    {1'b0,1'b0,8'h00,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd5},  // R5
    {1'b0,1'b1,8'h0F,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd6},  // R6
    {1'b1,1'b0,8'h0F,8'h5A,1'b0,1'b0, 1'b1,1'b1,1'b0,8'h00, 4'd5},  // R5
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b1, 1'b0,1'b0,1'b1,8'h00, 4'd5},  // R5
    {1'b1,1'b0,8'h03,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd10}, // R10
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd10}, // R10
    {1'b0,1'b0,8'h00,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b0,8'h00, 4'd10}, // R10
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b1, 1'b0,1'b0,1'b1,8'h00, 4'd3},  // R3
    {1'b0,1'b1,8'h03,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h00, 4'd10}  // R10
  };

  task automatic check(input int req, input logic es, eb, ed, input logic [7:0] er);
    n_run++;
    if (conv_start !== es || busy !== eb || done !== ed || rdata !== er) begin
      n_fail++;
      $display("FAIL R%0d: start/busy/done/rdata = %b/%b/%b/%h, expected %b/%b/%b/%h",
               req, conv_start, busy, done, rdata, es, eb, ed, er);
    end
  endtask

  task automatic step(input logic w, r, input logic [7:0] a, d, input logic t, c);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; sched_tick = t; conv_done = c;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; sched_tick = 0; conv_done = 0;
  endtask

  initial begin
    #(HALF * 2 * 20000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1, 0, 0, 0, 8'h00); // R1 during reset
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, 0, 0, 0, 8'h00);    // R1 after release

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      step(v[34], v[33], v[32:25], v[24:17], v[16], v[15]);
      check(int'(v[3:0]), v[14], v[13], v[12], v[11:4]);
    end

    // R1: reset in the middle of a conversion
    step(0, 0, 8'h00, 8'h00, 1, 0);
    check(2, 1, 1, 0, 8'h00);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    check(1, 0, 0, 0, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    step(0, 1, 8'h03, 8'h00, 0, 0);
    check(1, 0, 0, 0, 8'h00);

    // R7: only the standby bit of a configuration write is kept
    step(1, 0, 8'h03, 8'hFF, 0, 0);
    step(0, 1, 8'h03, 8'h00, 0, 0);
    check(7, 0, 0, 0, 8'h40);

    // R8: repeated trigger writes during one standby conversion
    step(1, 0, 8'h0F, 8'h33, 0, 0);
    check(5, 1, 1, 0, 8'h00);
    step(1, 0, 8'h0F, 8'h33, 0, 0);
    check(8, 0, 1, 0, 8'h00);
    step(0, 0, 8'h00, 8'h00, 0, 1);
    check(8, 0, 0, 1, 8'h00);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule